// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline whose stages run fetch, decode, execute, memory access and writeback. It watches the register numbers and control bits that the stage registers carry. From them it produces three kinds of output. The first is a bypass select for each ALU operand. The second is a stall that freezes the program counter and the fetch/decode register. The third is a bubble that zeroes the control bits entering execute. The ALU, the memories and the register file storage live outside the block.

The register file writes in the first half of a cycle and reads in the second half. A producer three instructions ahead of its consumer therefore reaches it through the file, and needs neither a bypass nor a stall. A producer one or two instructions ahead is bypassed from the execute/memory register or from the memory/writeback register. A load whose result is needed by the very next instruction cannot be bypassed in time, so it costs exactly one stall cycle. The pipeline has no branch prediction. When a conditional branch reaches decode, fetch is held for a fixed number of cycles while the branch resolves.

Top module: `hazard_unit`

## Requirements
- R1: An ALU operand whose execute-stage source register equals the destination held in the execute/memory register, with write enable set there, gets select 2'b10.
- R2: An ALU operand whose source matches only the memory/writeback destination, with write enable set there, gets select 2'b01. An operand with no match gets 2'b00, which means the register file value.
- R3: When both the execute/memory and the memory/writeback registers hold the matching destination with write enable set, the select is 2'b10. The younger result wins.
- R4: A stage whose register write enable is clear never causes a bypass or a stall, even when its destination number matches.
- R5: Register 0 is never a dependency. It is never bypassed and never causes a stall.
- R6: When the instruction in execute is a load (memory read and write enable set) and its destination equals a source that the decode-stage instruction uses, stall and bubble are both 1 in that cycle. A source whose use flag is clear does not count.
- R7: When a non-load instruction in execute produces a register read by decode, there is no stall, because the bypass covers it.
- R8: A producer in writeback and a consumer in decode cause no stall and no bypass select, because the register file's write-then-read covers the pair.
- R9: When a conditional branch is in decode and there is no stall, fetch_hold is 1 in that cycle and the following BR_WAIT-1 cycles (3 cycles in total by default), then falls. A branch flag seen while the hold is already counting does not extend it.
- R10: While a load-use stall is active, a branch in decode does not start the hold. The hold starts in the first cycle after the stall clears.
- R11: Reset clears any hold in progress. After reset with no branch in decode, fetch_hold, stall and bubble are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_src_a | input | RW | First source register of the decode-stage instruction |
| dec_src_b | input | RW | Second source register of the decode-stage instruction |
| dec_use_a | input | 1 | Decode instruction reads dec_src_a |
| dec_use_b | input | 1 | Decode instruction reads dec_src_b |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_src_a | input | RW | First ALU source register of the execute-stage instruction |
| ex_src_b | input | RW | Second ALU source register of the execute-stage instruction |
| ex_dst | input | RW | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_mem_rd | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RW | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | Write enable held in the execute/memory register |
| wb_dst | input | RW | Destination held in the memory/writeback register |
| wb_wr_en | input | 1 | Write enable held in the memory/writeback register |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Operand B select, same encoding |
| stall | output | 1 | Hold the program counter and the fetch/decode register |
| bubble | output | 1 | Zero the control bits entering execute |
| fetch_hold | output | 1 | Branch wait: hold fetch and feed decode a no-op |

## Verification
The bypass selects are tried with producers in each later stage, in both stages at once, with write enable clear, and with register 0. These patterns separate a wrong priority, a missing write-enable check and a missing zero check. The load-use tests put a load against a used source, against an unused source, and against a plain ALU producer, which tells a correct stall from one that is too eager or that ignores the load flag. The branch tests count the hold cycle by cycle, repeat the branch flag in mid-wait, overlap a branch with a load stall, and reset during the wait. These cases expose an off-by-one length, a hold that restarts, and a hold that ignores the stall.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int RW      = 5,
  parameter int BR_WAIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  input  logic          dec_is_branch,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr_en,
  input  logic          ex_mem_rd,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr_en,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr_en,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          fetch_hold
);

  localparam int CW = $clog2(BR_WAIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BR_WAIT - 1);

  logic          mem_live, wb_live, load_live;
  logic          hit_a, hit_b;
  logic [CW-1:0] wait_cnt;
  logic          br_start;

  assign mem_live  = mem_wr_en && (mem_dst != '0);
  assign wb_live   = wb_wr_en  && (wb_dst  != '0);
  assign load_live = ex_mem_rd && ex_wr_en && (ex_dst != '0);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic m_ok, input logic [RW-1:0] m_dst,
                                      input logic w_ok, input logic [RW-1:0] w_dst);
    if (m_ok && (m_dst == src))      return 2'b10;
    else if (w_ok && (w_dst == src)) return 2'b01;
    else                             return 2'b00;
  endfunction

  assign fwd_a = pick(ex_src_a, mem_live, mem_dst, wb_live, wb_dst);
  assign fwd_b = pick(ex_src_b, mem_live, mem_dst, wb_live, wb_dst);

  assign hit_a  = dec_use_a && (dec_src_a == ex_dst);
  assign hit_b  = dec_use_b && (dec_src_b == ex_dst);
  assign stall  = load_live && (hit_a || hit_b);
  assign bubble = stall;

  assign br_start   = dec_is_branch && !stall && (wait_cnt == '0);
  assign fetch_hold = br_start || (wait_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               wait_cnt <= '0;
    else if (br_start)        wait_cnt <= RELOAD;
    else if (wait_cnt != '0)  wait_cnt <= wait_cnt - 1'b1;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R2
  AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> (fwd_a == 2'b00)); // R5
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_mem_rd && ex_wr_en && bubble)); // R6
  AST_HOLD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold && !dec_is_branch) |-> $past(fetch_hold)); // R9
  AST_NO_HOLD_START_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !$past(fetch_hold)) |-> !fetch_hold); // R10
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= RELOAD); // R9

endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
  localparam int RW = 5;

  logic clk = 0;
  logic rst_n;
  logic [RW-1:0] dec_src_a, dec_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic dec_use_a, dec_use_b, dec_is_branch, ex_wr_en, ex_mem_rd, mem_wr_en, wb_wr_en;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, fetch_hold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hazard_unit #(.RW(RW), .BR_WAIT(3)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b), .dec_is_branch(dec_is_branch),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .ex_wr_en(ex_wr_en), .ex_mem_rd(ex_mem_rd),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble), .fetch_hold(fetch_hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_src_a = 0; dec_src_b = 0; dec_use_a = 0; dec_use_b = 0; dec_is_branch = 0;
    ex_src_a = 0; ex_src_b = 0; ex_dst = 0; ex_wr_en = 0; ex_mem_rd = 0;
    mem_dst = 0; mem_wr_en = 0; wb_dst = 0; wb_wr_en = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    settle(); settle();
    chk("R11 stall", stall, 0);
    chk("R11 hold", fetch_hold, 0);
    rst_n = 1;
    settle();
    chk("R11 fwd_a", fwd_a, 0);
    chk("R11 bubble", bubble, 0);
  endtask

  task automatic t_fwd();
    idle(); ex_src_a = 5; ex_src_b = 5; mem_dst = 5; mem_wr_en = 1; #1;
    chk("R1 fwd_a mem", fwd_a, 2); chk("R1 fwd_b mem", fwd_b, 2);
    idle(); ex_src_b = 7; wb_dst = 7; wb_wr_en = 1; ex_src_a = 3; #1;
    chk("R2 fwd_b wb", fwd_b, 1); chk("R2 fwd_a none", fwd_a, 0);
    idle(); ex_src_a = 9; mem_dst = 9; mem_wr_en = 1; wb_dst = 9; wb_wr_en = 1; #1;
    chk("R3 priority", fwd_a, 2);
    mem_wr_en = 0; #1;
    chk("R4 mem wr off falls to wb", fwd_a, 1);
    wb_wr_en = 0; #1;
    chk("R4 both off", fwd_a, 0);
    idle(); ex_src_a = 0; ex_src_b = 0; mem_wr_en = 1; wb_wr_en = 1; #1;
    chk("R5 zero fwd_a", fwd_a, 0); chk("R5 zero fwd_b", fwd_b, 0);
  endtask

  task automatic t_load_use();
    idle(); ex_dst = 4; ex_wr_en = 1; ex_mem_rd = 1; dec_src_b = 4; dec_use_b = 1; #1;
    chk("R6 stall", stall, 1); chk("R6 bubble", bubble, 1);
    dec_use_b = 0; #1;
    chk("R6 unused source", stall, 0);
    dec_use_a = 1; dec_src_a = 4; ex_wr_en = 0; #1;
    chk("R4 load no write", stall, 0);
    ex_wr_en = 1; ex_mem_rd = 0; #1;
    chk("R7 alu producer", stall, 0);
    idle(); ex_dst = 0; ex_wr_en = 1; ex_mem_rd = 1; dec_src_a = 0; dec_use_a = 1; #1;
    chk("R5 zero load", stall, 0);
    idle(); wb_dst = 6; wb_wr_en = 1; dec_src_a = 6; dec_use_a = 1; ex_src_a = 2; #1;
    chk("R8 no stall", stall, 0); chk("R8 no fwd", fwd_a, 0);
  endtask

  task automatic t_branch();
    idle(); settle();
    dec_is_branch = 1; #1;
    chk("R9 hold c1", fetch_hold, 1);
    settle(); dec_is_branch = 0; #1;
    chk("R9 hold c2", fetch_hold, 1);
    settle(); dec_is_branch = 1; #1;
    chk("R9 hold c3 (repeat ignored)", fetch_hold, 1);
    settle(); dec_is_branch = 0; #1;
    chk("R9 hold ends", fetch_hold, 0);
    settle();
    chk("R9 stays low", fetch_hold, 0);
  endtask

  task automatic t_branch_stall();
    idle(); settle();
    dec_is_branch = 1; dec_src_a = 8; dec_use_a = 1;
    ex_dst = 8; ex_wr_en = 1; ex_mem_rd = 1; #1;
    chk("R10 stall", stall, 1); chk("R10 no hold", fetch_hold, 0);
    settle(); ex_dst = 0; ex_wr_en = 0; ex_mem_rd = 0; #1;
    chk("R10 hold starts", fetch_hold, 1);
    settle(); dec_is_branch = 0; #1;
    chk("R10 hold c2", fetch_hold, 1);
    rst_n = 0; settle(); rst_n = 1; #1;
    chk("R11 reset clears hold", fetch_hold, 0);
  endtask

  initial begin
    idle(); rst_n = 0;
    t_reset();
    t_fwd();
    t_load_use();
    t_branch();
    t_branch_stall();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule